// File: doc/BRIEF.md
# Multi-format Wiegand frame transmitter

This block turns a credential value into a Wiegand frame and sends it bit by bit on two active-low data lines. A requester offers the value, a 3-bit format code and a per-key flag on a valid/ready handshake. When the block accepts the request, it works out the parity bits, lays the whole frame into one shift register, and then sends the bits one after another. Each bit is a fixed-width low pulse on one of the two lines, and a fixed pause follows every bit.

Six formats wrap the data in parity bits: 26, 30, 34, 40, 42 and 58 bits. In each of these, the first bit is even parity over the upper half of the data and the last bit is odd parity over the lower half. Two raw formats of 32 and 56 bits send the data with no parity. A per-key flag selects an 8-bit frame and overrides the format code. All formats use the same serializer and the same timer. Pulse and pause lengths are given in microseconds and converted to clock cycles through a cycles-per-microsecond parameter.

Top module: `wiegand_frame_tx`

## Requirements
- R1: After reset, `req_ready` is 1 and both data lines are 1. While `req_ready` is 1, both lines stay at 1.
- R2: A 0 bit is sent as a low pulse on `wg_d0_n` and a 1 bit as a low pulse on `wg_d1_n`. The two lines are never low together.
- R3: Every bit is low for exactly PULSE_US*CYC_PER_US cycles. It is followed by exactly GAP_US*CYC_PER_US cycles with both lines high, and this includes the last bit. The first pulse starts in the cycle after acceptance.
- R4: With `req_key`=0, `req_fmt` selects the frame length. Codes 0 to 5 select 26, 30, 34, 40, 42 and 58 bits. Code 6 selects 32 bits and code 7 selects 56 bits.
- R5: For codes 0 to 5, the data width is the frame length minus 2. The first frame bit makes the upper half of the data bits even. The last frame bit makes the lower half of the data bits odd.
- R6: Codes 6 and 7 send only data bits and add no parity bit.
- R7: `req_key`=1 sends an 8-bit frame of data bits only, whatever the value of `req_fmt`.
- R8: Data is right-aligned in `req_data` and goes out most significant bit first. Bits above the selected data width have no effect on the lines.
- R9: `req_ready` falls in the cycle after acceptance and stays low until the pause after the last bit has elapsed. A request offered while `req_ready` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle; a request is accepted when this and `req_valid` are both 1 |
| req_fmt | input | 3 | Format code (see R4) |
| req_key | input | 1 | Per-key 8-bit frame select |
| req_data | input | 56 | Credential value, right-aligned |
| wg_d0_n | output | 1 | Zero-bit line, active low |
| wg_d1_n | output | 1 | One-bit line, active low |

## Verification
The hardest case to reach is a second request that arrives while a frame is still going out. It must be ignored. The stimulus keeps `req_valid` high with different data and a different format for several cycles after acceptance, then drops it before the frame ends.

The data patterns include bits set above the selected width. They also include values chosen so that each parity bit comes out both 0 and 1. With these, the line sequence that is compared cycle by cycle shows whether the masking, the half split and the parity sense are right for every format code and for the per-key override.

// File: rtl/wiegand_frame_tx.sv
module wiegand_frame_tx #(
  parameter int CYC_PER_US = 50,
  parameter int PULSE_US   = 100,
  parameter int GAP_US     = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [2:0]  req_fmt,
  input  logic        req_key,
  input  logic [55:0] req_data,
  output logic        wg_d0_n,
  output logic        wg_d1_n
);
  localparam int FW        = 58;
  localparam int DW        = 56;
  localparam int PULSE_CYC = CYC_PER_US * PULSE_US;
  localparam int GAP_CYC   = CYC_PER_US * GAP_US;
  localparam int TMAX      = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
  localparam int TW        = $clog2(TMAX + 1);
  localparam int CW        = $clog2(FW + 1);

  typedef enum logic [1:0] {S_IDLE, S_PULSE, S_GAP} st_t;

  st_t           st;
  logic [FW-1:0] sreg;
  logic [CW-1:0] left;
  logic [TW-1:0] tmr;

  logic [CW-1:0] n_bits, d_bits;
  logic          has_par;
  logic [DW-1:0] dmask, lomask, dm;
  logic          p_even, p_odd;
  logic [FW-1:0] body, frame;

  always_comb begin
    has_par = 1'b1;
    n_bits  = CW'(26);
    if (req_key) begin
      n_bits  = CW'(8);
      has_par = 1'b0;
    end else begin
      case (req_fmt)
        3'd0: n_bits = CW'(26);
        3'd1: n_bits = CW'(30);
        3'd2: n_bits = CW'(34);
        3'd3: n_bits = CW'(40);
        3'd4: n_bits = CW'(42);
        3'd5: n_bits = CW'(58);
        3'd6: begin n_bits = CW'(32); has_par = 1'b0; end
        default: begin n_bits = CW'(56); has_par = 1'b0; end
      endcase
    end
    d_bits = has_par ? n_bits - CW'(2) : n_bits;
  end

  assign dmask  = DW'(({{DW{1'b0}}, 1'b1} << d_bits) - 1'b1);
  assign lomask = DW'(({{DW{1'b0}}, 1'b1} << (d_bits >> 1)) - 1'b1);
  assign dm     = req_data & dmask;
  assign p_even = ^(dm & dmask & ~lomask);
  assign p_odd  = ~^(dm & lomask);

  always_comb begin
    if (has_par)
      body = FW'({dm, p_odd}) | (FW'(p_even) << (d_bits + CW'(1)));
    else
      body = FW'(dm);
    frame = body << (CW'(FW) - n_bits);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      sreg <= '0;
      left <= '0;
      tmr  <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          st   <= S_PULSE;
          sreg <= frame;
          left <= n_bits;
          tmr  <= TW'(PULSE_CYC - 1);
        end
        S_PULSE: if (tmr == '0) begin
          st   <= S_GAP;
          sreg <= sreg << 1;
          left <= left - 1'b1;
          tmr  <= TW'(GAP_CYC - 1);
        end else tmr <= tmr - 1'b1;
        S_GAP: if (tmr == '0) begin
          if (left == '0) st <= S_IDLE;
          else begin
            st  <= S_PULSE;
            tmr <= TW'(PULSE_CYC - 1);
          end
        end else tmr <= tmr - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign wg_d0_n   = !(st == S_PULSE && !sreg[FW-1]);
  assign wg_d1_n   = !(st == S_PULSE &&  sreg[FW-1]);

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (wg_d0_n && wg_d1_n));

  p_one_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (wg_d0_n || wg_d1_n));

  p_pulse_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PULSE && tmr != '0) |=> $stable({wg_d0_n, wg_d1_n}));

  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && $countones({wg_d0_n, wg_d1_n}) == 1));

  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !(st == S_GAP && tmr == '0 && left == '0)) |=> !req_ready);
endmodule

// File: tb/wiegand_frame_tx_tb_top.sv
`timescale 1ns/1ps
module wiegand_frame_tx_tb_top;
  localparam int CPU = 1, PU = 3, GU = 5;
  localparam int PC = CPU * PU, GC = CPU * GU;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_fmt = '0;
  logic        req_key = 1'b0;
  logic [55:0] req_data = '0;
  logic        wg_d0_n, wg_d1_n;

  wiegand_frame_tx #(.CYC_PER_US(CPU), .PULSE_US(PU), .GAP_US(GU)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_fmt(req_fmt), .req_key(req_key), .req_data(req_data),
    .wg_d0_n(wg_d0_n), .wg_d1_n(wg_d1_n));

  int checks = 0, fails = 0;
  bit done = 0;
  string cur = "R1";
  logic [2:0] q[$];

  task automatic chk(string req, bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic void frame_info(input logic [2:0] f, input logic k,
                                     output int n, output int d, output bit par);
    int lens[8] = '{26, 30, 34, 40, 42, 58, 32, 56};
    n = k ? 8 : lens[f];
    par = !k && f < 6;
    d = par ? n - 2 : n;
  endfunction

  function automatic void push_frame(input logic [2:0] f, input logic k, input logic [55:0] v);
    int n, d; bit par;
    bit b[$];
    bit pe, po;
    frame_info(f, k, n, d, par);
    if (par) begin
      pe = 0; po = 1;
      for (int i = d / 2; i < d; i++) pe ^= v[i];
      for (int i = 0; i < d / 2; i++) po ^= v[i];
      b.push_back(pe);
    end
    for (int i = d - 1; i >= 0; i--) b.push_back(v[i]);
    if (par) b.push_back(po);
    foreach (b[j]) begin
      for (int c = 0; c < PC; c++) q.push_back({1'b0, b[j], ~b[j]});
      for (int c = 0; c < GC; c++) q.push_back(3'b111 & 3'b011);
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) q.delete();
    else if (q.size() > 0) void'(q.pop_front());
    else if (req_valid) push_frame(req_fmt, req_key, req_data);
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [2:0] e;
      e = (q.size() > 0) ? q[0] : 3'b111;
      chk(cur, {req_ready, wg_d0_n, wg_d1_n} == e, "ready/d0/d1",
          longint'({req_ready, wg_d0_n, wg_d1_n}), longint'(e));
    end
  end

  task automatic send(string tag, logic [2:0] f, logic k, logic [55:0] v, int hold);
    int n, d, cnt; bit par;
    cur = tag;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_fmt = f; req_key = k; req_data = v;
    @(negedge clk);
    for (int h = 0; h < hold; h++) begin
      req_fmt = ~f; req_key = ~k; req_data = ~v;
      @(negedge clk);
    end
    req_valid = 1'b0;
    frame_info(f, k, n, d, par);
    cnt = hold;
    while (!req_ready) begin cnt++; @(negedge clk); end
    chk("R3", cnt == n * (PC + GC), "busy cycles", cnt, n * (PC + GC));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk("R9", 1'b0, "watchdog expired", 0, 1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", req_ready && wg_d0_n && wg_d1_n, "reset state",
        longint'({req_ready, wg_d0_n, wg_d1_n}), 7);
    repeat (2) @(negedge clk);
    // R4 R5: each parity format, patterns flipping parity sense
    send("R5", 3'd0, 1'b0, 56'h0000_0000_ABCDEF, 0);
    send("R5", 3'd0, 1'b0, 56'h0000_0000_000001, 0);
    send("R4", 3'd1, 1'b0, 56'h0000_0000_FFFFFFF, 0);
    send("R4", 3'd2, 1'b0, 56'h0000_0000_80000001, 0);
    send("R5", 3'd3, 1'b0, 56'h0000_0035_5AA55AA5, 0);
    send("R5", 3'd4, 1'b0, 56'h0000_00FF_00000000, 0);
    send("R5", 3'd5, 1'b0, 56'h12_3456_789A_BCDE, 0);
    send("R5", 3'd5, 1'b0, 56'h00_0000_0000_0000, 0);
    // R6: raw formats
    send("R6", 3'd6, 1'b0, 56'h0000_00DE_ADBEEF, 0);
    send("R6", 3'd7, 1'b0, 56'hFE_DCBA_9876_5432, 0);
    // R7: per-key overrides format code
    send("R7", 3'd5, 1'b1, 56'h0000_0000_0000A5, 0);
    send("R7", 3'd7, 1'b1, 56'h0000_0000_00003C, 0);
    // R8: garbage above data width is ignored
    send("R8", 3'd0, 1'b0, 56'hFF_FFFF_FF12_3456, 0);
    send("R8", 3'd6, 1'b1, 56'hFF_FFFF_FFFF_FF81, 0);
    send("R8", 3'd2, 1'b0, {$urandom(), $urandom()} & 56'hFF_FFFF_FFFF_FFFF, 0);
    // R9: request held while busy is ignored
    send("R9", 3'd1, 1'b0, 56'h0000_0000_1234567, 5);
    send("R9", 3'd6, 1'b1, 56'h0000_0000_0000C3, 20);
    // R2: alternating bits on both lines
    send("R2", 3'd7, 1'b0, 56'hAA_AAAA_AAAA_AAAA, 0);
    repeat (4) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule